// File: doc/BRIEF.md
# Vector Floating-Point Compare Mask Generator

This block takes two 128-bit vectors and compares them element by element as IEEE binary32 values (four lanes) or binary64 values (two lanes). Each lane receives an all-ones or all-zeros mask that reflects whether the selected predicate holds. A 2-bit condition code reports whether all, some or none of the evaluated lanes matched. An invalid-operation flag is raised when a NaN reaches the compare, and the signaling/quiet select decides which NaNs count.

The compare works directly on the integer encodings, with no arithmetic unit, and takes one cycle of combinational logic. A parameter puts an output register after that logic. With the default setting a result appears one clock after its request is presented. A single-element control restricts the work to lane 0, so the same block serves both scalar and vector compare operations.

Top module: `vfp_cmp_mask`

## Requirements
- R1: A lane whose predicate holds is written as all ones in `mask`. Every other lane, including a lane that is not evaluated, is written as all zeros.
- R2: Lane 0 is the most significant element of each operand and of `mask`. With `fmt_dbl`=0 there are four 32-bit lanes (lane i at bits [127-32i -: 32]). With `fmt_dbl`=1 there are two 64-bit lanes (lane i at bits [127-64i -: 64]).
- R3: `pred` encoding: 0 = equal; 1 = high (`op_b` lane less than `op_a` lane); 2 = high-or-equal (`op_b` lane less than or equal to `op_a` lane); 3 = no lane ever matches.
- R4: A NaN operand (exponent all ones, fraction nonzero) makes the lane's predicate false. +0 and -0 compare equal. Other values are ordered by sign and magnitude, with infinities as the extremes.
- R5: With `single`=0, `cc` is 0 when every lane matched, 1 when some but not all lanes matched, and 3 when no lane matched. `cc` is never 2.
- R6: With `single`=1, only lane 0 is evaluated and every other lane of `mask` is zero. `cc` is 0 if lane 0 matched and 3 otherwise.
- R7: With `sig_cmp`=0, `invalid` is 1 only when an evaluated lane holds a signaling NaN (fraction MSB clear). With `sig_cmp`=1, any NaN in an evaluated lane sets `invalid`. Lanes that are not evaluated never set it.
- R8: With `OUT_REG`=1, the outputs for a request with `in_valid`=1 appear together with `out_valid`=1 at the next clock edge. `out_valid` is 0 otherwise. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| fmt_dbl | input | 1 | 0 = four binary32 lanes, 1 = two binary64 lanes |
| pred | input | 2 | Predicate select (equal, high, high-or-equal) |
| sig_cmp | input | 1 | 1 = signaling compare, 0 = quiet compare |
| single | input | 1 | Evaluate lane 0 only |
| op_a | input | 128 | Second operand vector |
| op_b | input | 128 | Third operand vector |
| out_valid | output | 1 | Result present |
| mask | output | 128 | Per-lane result mask |
| cc | output | 2 | Condition code |
| invalid | output | 1 | Invalid-operation indication |

## Verification
The assertions assume that a new request's control fields only matter in the cycle where `in_valid` is high. They also assume the default registered output stage, which the single-element and latency properties depend on. The bench keeps every control input steady for the cycle of each request and drops `in_valid` in between. Some requests are issued back to back, so each result is still compared against the request that produced it. The operands are chosen by hand to reach the corner cases: mixed signs, equal magnitudes, signed zeros, infinities, quiet and signaling NaNs, and lanes beyond lane 0 that would change the outcome if single-element mode leaked.

// File: rtl/vfp_cmp_pkg.sv
// Shared encodings for the vector floating-point compare mask generator.
package vfp_cmp_pkg;
    typedef enum logic [1:0] {
        PRED_EQ   = 2'd0,
        PRED_HI   = 2'd1,
        PRED_HE   = 2'd2,
        PRED_NONE = 2'd3
    } pred_e;

    localparam logic [1:0] CC_ALL  = 2'd0;
    localparam logic [1:0] CC_SOME = 2'd1;
    localparam logic [1:0] CC_NONE = 2'd3;
endpackage

// File: rtl/vfp_lane_cmp.sv
// One-lane IEEE compare on raw encodings.
// Assumes: EW-bit value with FW fraction bits and one sign bit; the exponent
// takes the remaining bits. A lane with en=0 reports no hit and no invalid.
module vfp_lane_cmp
    import vfp_cmp_pkg::*;
#(
    parameter int EW = 32,
    parameter int FW = 23
) (
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    input  logic [1:0]    pred,
    input  logic          sig_cmp,
    input  logic          en,
    output logic          hit,
    output logic          inv
);
    localparam int XW = EW - 1 - FW;

    logic          a_s, b_s;
    logic [EW-2:0] a_mag, b_mag;
    logic          a_nan, b_nan, a_snan, b_snan;
    logic          a_zero, b_zero;
    logic          eq, b_lt_a, raw;
    pred_e         p;

    // Field decode for both operands
    always_comb begin
        a_s    = a[EW-1];
        b_s    = b[EW-1];
        a_mag  = a[EW-2:0];
        b_mag  = b[EW-2:0];
        a_nan  = (a[EW-2 -: XW] == {XW{1'b1}}) && (a[FW-1:0] != '0);
        b_nan  = (b[EW-2 -: XW] == {XW{1'b1}}) && (b[FW-1:0] != '0);
        a_snan = a_nan && !a[FW-1];
        b_snan = b_nan && !b[FW-1];
        a_zero = (a_mag == '0);
        b_zero = (b_mag == '0);
    end

    // Sign-magnitude ordering and equality
    always_comb begin
        eq = (a_zero && b_zero) || (a == b);
        if (a_zero && b_zero)
            b_lt_a = 1'b0;
        else if (a_s != b_s)
            b_lt_a = b_s;
        else if (!a_s)
            b_lt_a = (b_mag < a_mag);
        else
            b_lt_a = (b_mag > a_mag);
    end

    // Predicate select, NaN masking and invalid detection
    always_comb begin
        p = pred_e'(pred);
        case (p)
            PRED_EQ: raw = eq;
            PRED_HI: raw = b_lt_a;
            PRED_HE: raw = b_lt_a || eq;
            default: raw = 1'b0;
        endcase
        hit = en && !a_nan && !b_nan && raw;
        inv = en && (sig_cmp ? (a_nan || b_nan) : (a_snan || b_snan));
    end
endmodule

// File: rtl/vfp_cc_reduce.sv
// Reduces per-lane hits to the condition code.
// Assumes: act marks the lanes that take part; hit is already zero elsewhere;
// lane 0 is bit 0.
module vfp_cc_reduce
    import vfp_cmp_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] hit,
    input  logic [LANES-1:0] act,
    input  logic             single,
    output logic [1:0]       cc
);
    // All / some / none summary with single-element override
    always_comb begin
        if (single)
            cc = hit[0] ? CC_ALL : CC_NONE;
        else if ((hit & act) == act)
            cc = CC_ALL;
        else if (|hit)
            cc = CC_SOME;
        else
            cc = CC_NONE;
    end
endmodule

// File: rtl/vfp_out_stage.sv
// Optional output register for the compare results.
// Assumes: OUT_REG=1 registers with a synchronous active-low reset;
// OUT_REG=0 passes the inputs straight through.
module vfp_out_stage #(
    parameter int VEC_W   = 128,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v_in,
    input  logic [VEC_W-1:0] m_in,
    input  logic [1:0]       cc_in,
    input  logic             inv_in,
    output logic             v_out,
    output logic [VEC_W-1:0] m_out,
    output logic [1:0]       cc_out,
    output logic             inv_out
);
    generate
        if (OUT_REG) begin : g_reg
            // Capture results; outputs of an idle cycle are cleared
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_out   <= 1'b0;
                    m_out   <= '0;
                    cc_out  <= 2'd0;
                    inv_out <= 1'b0;
                end else begin
                    v_out   <= v_in;
                    m_out   <= v_in ? m_in : '0;
                    cc_out  <= v_in ? cc_in : 2'd0;
                    inv_out <= v_in && inv_in;
                end
            end
        end else begin : g_pass
            assign v_out   = v_in;
            assign m_out   = m_in;
            assign cc_out  = cc_in;
            assign inv_out = inv_in;
        end
    endgenerate
endmodule

// File: rtl/vfp_cmp_mask.sv
// Vector floating-point compare mask generator (top).
// Assumes: VEC_W is a multiple of 64; lane 0 is the most significant element.
// Builds both lane widths in parallel and selects one with fmt_dbl.
module vfp_cmp_mask #(
    parameter int VEC_W   = 128,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             fmt_dbl,
    input  logic [1:0]       pred,
    input  logic             sig_cmp,
    input  logic             single,
    input  logic [VEC_W-1:0] op_a,
    input  logic [VEC_W-1:0] op_b,
    output logic             out_valid,
    output logic [VEC_W-1:0] mask,
    output logic [1:0]       cc,
    output logic             invalid
);
    localparam int L32 = VEC_W / 32;
    localparam int L64 = VEC_W / 64;

    logic [L32-1:0]   hit32, inv32, en32;
    logic [L64-1:0]   hit64, inv64, en64;
    logic [VEC_W-1:0] mask32, mask64, mask_c;
    logic [L32-1:0]   hit_sel, act_sel;
    logic [1:0]       cc_c;
    logic             inv_c;

    genvar i;
    generate
        for (i = 0; i < L32; i++) begin : g_s
            assign en32[i] = !fmt_dbl && (!single || (i == 0));
            vfp_lane_cmp #(.EW(32), .FW(23)) u_lane (
                .a       (op_a[VEC_W-1-32*i -: 32]),
                .b       (op_b[VEC_W-1-32*i -: 32]),
                .pred    (pred),
                .sig_cmp (sig_cmp),
                .en      (en32[i]),
                .hit     (hit32[i]),
                .inv     (inv32[i])
            );
            assign mask32[VEC_W-1-32*i -: 32] = {32{hit32[i]}};
        end
        for (i = 0; i < L64; i++) begin : g_d
            assign en64[i] = fmt_dbl && (!single || (i == 0));
            vfp_lane_cmp #(.EW(64), .FW(52)) u_lane (
                .a       (op_a[VEC_W-1-64*i -: 64]),
                .b       (op_b[VEC_W-1-64*i -: 64]),
                .pred    (pred),
                .sig_cmp (sig_cmp),
                .en      (en64[i]),
                .hit     (hit64[i]),
                .inv     (inv64[i])
            );
            assign mask64[VEC_W-1-64*i -: 64] = {64{hit64[i]}};
        end
        for (i = 0; i < L32; i++) begin : g_sel
            // Lane hits and participating lanes for the selected format
            if (i < L64) begin : g_lo
                assign hit_sel[i] = fmt_dbl ? hit64[i] : hit32[i];
                assign act_sel[i] = 1'b1;
            end else begin : g_hi
                assign hit_sel[i] = fmt_dbl ? 1'b0 : hit32[i];
                assign act_sel[i] = !fmt_dbl;
            end
        end
    endgenerate

    // Format select of the mask and merged invalid indication
    always_comb begin
        mask_c = fmt_dbl ? mask64 : mask32;
        inv_c  = (|inv32) || (|inv64);
    end

    vfp_cc_reduce #(.LANES(L32)) u_cc (
        .hit    (hit_sel),
        .act    (act_sel),
        .single (single),
        .cc     (cc_c)
    );

    vfp_out_stage #(.VEC_W(VEC_W), .OUT_REG(OUT_REG)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .v_in    (in_valid),
        .m_in    (mask_c),
        .cc_in   (cc_c),
        .inv_in  (inv_c),
        .v_out   (out_valid),
        .m_out   (mask),
        .cc_out  (cc),
        .inv_out (invalid)
    );
endmodule

// File: rtl/vfp_cmp_mask_chk.sv
// Property checker for vfp_cmp_mask, attached by bind.
module vfp_cmp_mask_chk #(
    parameter int VEC_W   = 128,
    parameter bit OUT_REG = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             fmt_dbl,
    input logic             single,
    input logic             out_valid,
    input logic [VEC_W-1:0] mask,
    input logic [1:0]       cc,
    input logic             invalid
);
    localparam int NW = VEC_W / 32;

    genvar w;
    generate
        for (w = 0; w < NW; w++) begin : g_w
            // R1: every 32-bit word of a result is uniform
            p_word_uniform_r1: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (mask[32*w +: 32] == '0 || mask[32*w +: 32] == '1));
        end
    endgenerate

    // R5: code 2 never appears
    p_cc_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> cc != 2'd2);

    // R5: no-match code goes with an empty mask
    p_cc_none_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cc == 2'd3) |-> mask == '0);

    // R5: partial-match code goes with a mask that is neither empty nor full
    p_cc_some_partial_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cc == 2'd1) |-> (mask != '0 && mask != '1));

    // R1: all-match code needs at least one set lane
    p_cc_all_nonempty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cc == 2'd0) |-> mask != '0);

    generate
        if (OUT_REG) begin : g_seq
            // R8: a request yields a result one cycle later
            p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            // R8: no request, no result
            p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            // R6: single-element binary32 leaves lanes 1..3 zero
            p_single_s_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && $past(single) && !$past(fmt_dbl)) |-> mask[VEC_W-33:0] == '0);
            // R6: single-element binary64 leaves lane 1 zero
            p_single_d_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && $past(single) && $past(fmt_dbl)) |-> mask[VEC_W-65:0] == '0);
            // R8: idle output cycles carry no invalid indication
            p_idle_inv_r8: assert property (@(posedge clk) disable iff (!rst_n)
                !out_valid |-> !invalid);
        end
    endgenerate
endmodule

bind vfp_cmp_mask vfp_cmp_mask_chk #(.VEC_W(VEC_W), .OUT_REG(OUT_REG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .fmt_dbl   (fmt_dbl),
    .single    (single),
    .out_valid (out_valid),
    .mask      (mask),
    .cc        (cc),
    .invalid   (invalid)
);

// File: tb/tb_vfp_cmp_mask.sv
`timescale 1ns/1ps
module tb_vfp_cmp_mask;
    localparam logic [31:0] P1 = 32'h3F80_0000, P2 = 32'h4000_0000;
    localparam logic [31:0] N1 = 32'hBF80_0000, N2 = 32'hC000_0000;
    localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
    localparam logic [31:0] QN = 32'h7FC0_0000, SN = 32'h7F80_0001;
    localparam logic [31:0] PI = 32'h7F80_0000, MX = 32'h7F7F_FFFF;
    localparam logic [63:0] D1 = 64'h3FF0_0000_0000_0000, D2 = 64'h4000_0000_0000_0000;
    localparam logic [63:0] DNI = 64'hFFF0_0000_0000_0000, DQN = 64'h7FF8_0000_0000_0000;
    localparam logic [31:0] W1 = 32'hFFFF_FFFF, W0 = 32'h0;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0, fmt_dbl = 1'b0, sig_cmp = 1'b0, single = 1'b0;
    logic [1:0]   pred = 2'd0;
    logic [127:0] op_a = '0, op_b = '0;
    logic         out_valid, invalid;
    logic [127:0] mask;
    logic [1:0]   cc;

    int checks = 0, failures = 0, cyc = 0;
    bit finished = 1'b0;

    logic [127:0] q_mask[$];
    logic [1:0]   q_cc[$];
    logic         q_inv[$];
    int           q_cyc[$];
    string        q_tag[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    vfp_cmp_mask dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_dbl(fmt_dbl),
        .pred(pred), .sig_cmp(sig_cmp), .single(single), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .mask(mask), .cc(cc), .invalid(invalid)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: present one request and queue its expected result
    task automatic send(input logic fd, input logic [1:0] p, input logic sg, input logic se,
                        input logic [127:0] a, input logic [127:0] b,
                        input logic [127:0] em, input logic [1:0] ec, input logic ei,
                        input string tag);
        @(negedge clk);
        in_valid = 1'b1; fmt_dbl = fd; pred = p; sig_cmp = sg; single = se;
        op_a = a; op_b = b;
        q_mask.push_back(em); q_cc.push_back(ec); q_inv.push_back(ei);
        q_cyc.push_back(cyc + 1); q_tag.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: pop and compare each result as it appears
    always @(negedge clk) begin
        if (rst_n && out_valid && !finished) begin
            if (q_mask.size() == 0) begin
                check(1'b0, "R8 unexpected out_valid", 128'(out_valid), 128'd0);
            end else begin
                automatic logic [127:0] em = q_mask.pop_front();
                automatic logic [1:0]   ec = q_cc.pop_front();
                automatic logic         ei = q_inv.pop_front();
                automatic int           ey = q_cyc.pop_front();
                automatic string        tg = q_tag.pop_front();
                check(mask == em, {tg, " mask"}, mask, em);
                check(cc == ec, {tg, " cc"}, 128'(cc), 128'(ec));
                check(invalid == ei, {tg, " invalid"}, 128'(invalid), 128'(ei));
                check(cyc == ey, "R8 latency", 128'(cyc), 128'(ey));
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check(out_valid == 1'b0 && mask == '0 && cc == 2'd0 && invalid == 1'b0,
              "R8 reset", {out_valid, invalid, cc, mask[123:0]}, 128'd0);
        @(negedge clk) rst_n = 1'b1;
        idle();

        send(0, 2'd0, 0, 0, {P1, P2, N1, PZ}, {P1, P1, N1, NZ},
             {W1, W0, W1, W1}, 2'd1, 0, "R1 R4 eq signed zero");
        idle();
        send(0, 2'd1, 0, 0, {P2, P1, N1, N2}, {P1, P2, N2, N1},
             {W1, W0, W1, W0}, 2'd1, 0, "R3 R4 high mixed signs");
        send(0, 2'd2, 0, 0, {P1, P2, PZ, NZ}, {P1, P1, NZ, PZ},
             '1, 2'd0, 0, "R3 R5 high-or-equal all");
        send(0, 2'd3, 0, 0, {P1, P1, P1, P1}, {P1, P1, P1, P1},
             '0, 2'd3, 0, "R3 reserved predicate");
        idle();
        send(0, 2'd0, 0, 0, {P1, P1, P1, P1}, {P2, P2, P2, P2},
             '0, 2'd3, 0, "R5 none match");
        send(0, 2'd0, 0, 0, {QN, P1, P1, P1}, {QN, P1, P1, P1},
             {W0, W1, W1, W1}, 2'd1, 0, "R4 R7 quiet qNaN");
        send(0, 2'd0, 1, 0, {QN, P1, P1, P1}, {QN, P1, P1, P1},
             {W0, W1, W1, W1}, 2'd1, 1, "R7 signaling qNaN");
        send(0, 2'd0, 0, 0, {P1, P1, P1, SN}, {P1, P1, P1, P1},
             {W1, W1, W1, W0}, 2'd1, 1, "R7 quiet sNaN");
        idle();
        send(0, 2'd1, 0, 0, {PI, P1, P1, P1}, {MX, P1, P1, P1},
             {W1, W0, W0, W0}, 2'd1, 0, "R4 infinity above max");
        send(0, 2'd0, 0, 1, {P1, P1, P1, P1}, {P1, P1, P1, P1},
             {W1, W0, W0, W0}, 2'd0, 0, "R6 single match");
        send(0, 2'd0, 1, 1, {P1, SN, P1, P1}, {P2, P1, P1, P1},
             '0, 2'd3, 0, "R6 R7 single no match");
        idle();
        send(1, 2'd1, 0, 0, {D2, D1}, {D1, D1},
             {W1, W1, W0, W0}, 2'd1, 0, "R2 binary64 high");
        send(1, 2'd2, 0, 0, {D1, DNI}, {D1, DNI},
             '1, 2'd0, 0, "R2 R5 binary64 all");
        send(1, 2'd0, 0, 0, {DQN, D1}, {DQN, D1},
             {W0, W0, W1, W1}, 2'd1, 0, "R2 R4 binary64 qNaN");
        send(1, 2'd0, 0, 1, {D1, D1}, {D1, D2},
             {W1, W1, W0, W0}, 2'd0, 0, "R6 binary64 single");
        idle();
        repeat (4) @(negedge clk);
        check(q_mask.size() == 0, "R8 all results seen", 128'(q_mask.size()), 128'd0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule